// File: doc/BRIEF.md
# Data-Side Address Translation Checker

This block stands between a load/store unit and a fully associative translation cache. Each cycle it takes one data request and decides four things. It works out the physical address. It decides whether the translation is usable in this cycle. It checks whether the page permissions allow the request. It picks the single exception that the request raises, if any. On a cache hit it joins the cached physical page number with the page offset. For a superpage it substitutes the low page-number fields from the virtual address. It then checks read, write, dirty and privilege rules and applies the verdict of an external protection comparator.

On a cache miss it passes on errors reported by the page table walker. When translation is switched off, the virtual address is used unchanged as the physical address, and only the protection verdict applies. The block drives the page number and the fault outputs in the request cycle. The full physical address comes out of a register one cycle later. A combinational copy of the physical address is also driven to the protection comparator, so that its verdict arrives in the same cycle.

Top module: `lsu_xlat_check`

## Requirements
- R1: While reset is high, the registered physical address output reads zero.
- R2: When translation is in use, the valid output is high only on a cache hit or on a walker error. A miss with no walker error gives valid low and no exception.
- R3: The physical address is the cached page number followed by the 12-bit page offset. Page level 0 is a 4 KiB page, 1 is a 2 MiB page and 2 is a 1 GiB page. At level L, the lowest L 9-bit page-number fields come from the virtual address bits just above the offset.
- R4: The page number output is valid in the request cycle. The registered physical address shows that cycle's address after the next rising clock edge.
- R5: A store that hits raises a store page fault (cause 15) when the page is not writable, when its dirty bit is clear, or when the privilege check fails.
- R6: A load that hits raises a load page fault (cause 13) when the page is not readable, or when the privilege check fails. An execute-only page counts as readable when the make-executable-readable input is set.
- R7: Privilege check: in user mode the page must have its user bit set. In supervisor mode a user page is allowed only while the supervisor-user-access input is set.
- R8: A protection denial on a hit raises an access fault: cause 5 for a load, cause 7 for a store. A page fault on the same request wins over the access fault.
- R9: On a miss, a walker page error becomes the page fault for the request type (13 or 15). A walker access error is always reported with cause 5, even for a store.
- R10: With translation off, the physical address equals the zero-extended virtual address. A protection denial on a valid, aligned request raises cause 5 or 7. No page fault is raised in this mode.
- R11: A request marked misaligned is not translated and raises no exception. Its valid output follows the request, and its address passes through untranslated.
- R12: No exception and no valid are raised without a request. The trap value is the zero-extended virtual address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_valid_i | input | 1 | Data request present |
| req_store_i | input | 1 | Request is a store (0 = load) |
| req_vaddr_i | input | VA_W | Virtual address |
| req_misalign_i | input | 1 | Request already carries a misaligned exception |
| xlat_on_i | input | 1 | Translation enabled for data accesses |
| user_mode_i | input | 1 | Effective data privilege is user (0 = supervisor) |
| sum_i | input | 1 | Supervisor may access user pages |
| mxr_i | input | 1 | Execute-only pages readable by loads |
| tlb_hit_i | input | 1 | Translation cache hit |
| tlb_ppn_i | input | PPN_W | Cached physical page number |
| tlb_lvl_i | input | LVL_W | Page level of the hit entry (0 = base page) |
| tlb_r_i | input | 1 | Page readable |
| tlb_w_i | input | 1 | Page writable |
| tlb_x_i | input | 1 | Page executable |
| tlb_u_i | input | 1 | User page |
| tlb_d_i | input | 1 | Page dirty |
| walk_err_i | input | 1 | Walker reports an error for this request |
| walk_access_i | input | 1 | Walker error is an access error (0 = page error) |
| prot_addr_o | output | PA_W | Combinational physical address for the protection comparator |
| prot_deny_i | input | 1 | Protection comparator rejects the access |
| xlat_valid_o | output | 1 | Translation result valid this cycle |
| ppn_o | output | PPN_W | Physical page number, same cycle |
| paddr_o | output | PA_W | Physical address, registered |
| exc_valid_o | output | 1 | Exception raised |
| exc_cause_o | output | XLEN | Exception cause code |
| exc_tval_o | output | XLEN | Exception trap value |

## Verification
The assertions assume that cache attributes, walker flags and the protection verdict are steady and meaningful during the cycle they are sampled. They also assume that the page level stays below the number of translation levels. The checks also take it that a walker error and a hit are never signalled together, since a hit outranks the walker. The bench drives every input once per cycle on the falling edge and uses only levels 0 to 2. It never raises the walker flags together with a hit, so the stimulus stays inside these assumptions.

// File: rtl/lsu_xc_pkg.sv
package lsu_xc_pkg;

    typedef enum logic [4:0] {
        CODE_LD_ACCESS = 5'd5,
        CODE_ST_ACCESS = 5'd7,
        CODE_LD_PAGE   = 5'd13,
        CODE_ST_PAGE   = 5'd15
    } fault_code_e;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_ACCESS,
        KIND_PAGE
    } fault_kind_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
        logic usr;
        logic dirty;
    } page_attr_t;

    // Map a fault kind to its cause; a walker access error forces the load code
    function automatic fault_code_e code_for(fault_kind_e kind, logic is_store, logic force_load);
        fault_code_e c;
        if (kind == KIND_PAGE)
            c = is_store ? CODE_ST_PAGE : CODE_LD_PAGE;
        else
            c = (is_store && !force_load) ? CODE_ST_ACCESS : CODE_LD_ACCESS;
        return c;
    endfunction

endpackage

// File: rtl/lsu_xc_addr.sv
module lsu_xc_addr #(
    parameter int VA_W   = 39,
    parameter int PA_W   = 56,
    parameter int OFF_W  = 12,
    parameter int SEG_W  = 9,
    parameter int LEVELS = 3,
    localparam int PPN_W = PA_W - OFF_W,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic [VA_W-1:0]  vaddr_i,
    input  logic [PPN_W-1:0] ppn_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             use_xlat_i,
    output logic [PPN_W-1:0] ppn_o,
    output logic [PA_W-1:0]  paddr_o
);
    logic [PPN_W-1:0] patched;
    logic [PA_W-1:0]  bare;

    always_comb begin
        patched = ppn_i;
        for (int i = 0; i < LEVELS - 1; i++) begin
            if (int'(lvl_i) > i)
                patched[i*SEG_W +: SEG_W] = vaddr_i[OFF_W + i*SEG_W +: SEG_W];
        end
    end

    assign bare    = PA_W'(vaddr_i);
    assign paddr_o = use_xlat_i ? {patched, vaddr_i[OFF_W-1:0]} : bare;
    assign ppn_o   = paddr_o[PA_W-1:OFF_W];

endmodule

// File: rtl/lsu_xc_perm.sv
module lsu_xc_perm
    import lsu_xc_pkg::*;
(
    input  page_attr_t attr_i,
    input  logic       is_store_i,
    input  logic       user_mode_i,
    input  logic       sum_i,
    input  logic       mxr_i,
    output logic       page_fault_o
);
    logic priv_bad;
    logic rd_ok;

    always_comb begin
        priv_bad = user_mode_i ? !attr_i.usr : (attr_i.usr && !sum_i);
        rd_ok    = attr_i.rd || (attr_i.ex && mxr_i);
        if (is_store_i)
            page_fault_o = !attr_i.wr || !attr_i.dirty || priv_bad;
        else
            page_fault_o = !rd_ok || priv_bad;
    end

endmodule

// File: rtl/lsu_xc_fault.sv
module lsu_xc_fault
    import lsu_xc_pkg::*;
(
    input  logic        req_valid_i,
    input  logic        is_store_i,
    input  logic        misalign_i,
    input  logic        xlat_on_i,
    input  logic        hit_i,
    input  logic        page_fault_i,
    input  logic        deny_i,
    input  logic        walk_err_i,
    input  logic        walk_access_i,
    output logic        valid_o,
    output logic        exc_o,
    output fault_code_e code_o
);
    fault_kind_e kind;
    logic        force_load;

    always_comb begin
        valid_o    = 1'b0;
        kind       = KIND_NONE;
        force_load = 1'b0;
        if (req_valid_i) begin
            if (!xlat_on_i || misalign_i) begin
                valid_o = 1'b1;
                if (!misalign_i && deny_i) kind = KIND_ACCESS;
            end else if (hit_i) begin
                valid_o = 1'b1;
                if (page_fault_i)  kind = KIND_PAGE;
                else if (deny_i)   kind = KIND_ACCESS;
            end else if (walk_err_i) begin
                valid_o    = 1'b1;
                kind       = walk_access_i ? KIND_ACCESS : KIND_PAGE;
                force_load = walk_access_i;
            end
        end
        exc_o  = (kind != KIND_NONE);
        code_o = code_for(kind, is_store_i, force_load);
    end

endmodule

// File: rtl/lsu_xlat_check.sv
module lsu_xlat_check
    import lsu_xc_pkg::*;
#(
    parameter int VA_W   = 39,
    parameter int PA_W   = 56,
    parameter int OFF_W  = 12,
    parameter int SEG_W  = 9,
    parameter int LEVELS = 3,
    parameter int XLEN   = 64,
    localparam int PPN_W = PA_W - OFF_W,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             req_valid_i,
    input  logic             req_store_i,
    input  logic [VA_W-1:0]  req_vaddr_i,
    input  logic             req_misalign_i,
    input  logic             xlat_on_i,
    input  logic             user_mode_i,
    input  logic             sum_i,
    input  logic             mxr_i,
    input  logic             tlb_hit_i,
    input  logic [PPN_W-1:0] tlb_ppn_i,
    input  logic [LVL_W-1:0] tlb_lvl_i,
    input  logic             tlb_r_i,
    input  logic             tlb_w_i,
    input  logic             tlb_x_i,
    input  logic             tlb_u_i,
    input  logic             tlb_d_i,
    input  logic             walk_err_i,
    input  logic             walk_access_i,
    output logic [PA_W-1:0]  prot_addr_o,
    input  logic             prot_deny_i,
    output logic             xlat_valid_o,
    output logic [PPN_W-1:0] ppn_o,
    output logic [PA_W-1:0]  paddr_o,
    output logic             exc_valid_o,
    output logic [XLEN-1:0]  exc_cause_o,
    output logic [XLEN-1:0]  exc_tval_o
);
    logic        use_xlat;
    logic        pg_fault;
    page_attr_t  attr;
    fault_code_e code;
    logic [PA_W-1:0] pa_now;
    logic [PA_W-1:0] pa_q;

    assign use_xlat = xlat_on_i && !req_misalign_i;
    assign attr     = '{rd: tlb_r_i, wr: tlb_w_i, ex: tlb_x_i, usr: tlb_u_i, dirty: tlb_d_i};

    lsu_xc_addr #(
        .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .SEG_W(SEG_W), .LEVELS(LEVELS)
    ) u_addr (
        .vaddr_i    (req_vaddr_i),
        .ppn_i      (tlb_ppn_i),
        .lvl_i      (tlb_lvl_i),
        .use_xlat_i (use_xlat),
        .ppn_o      (ppn_o),
        .paddr_o    (pa_now)
    );

    lsu_xc_perm u_perm (
        .attr_i       (attr),
        .is_store_i   (req_store_i),
        .user_mode_i  (user_mode_i),
        .sum_i        (sum_i),
        .mxr_i        (mxr_i),
        .page_fault_o (pg_fault)
    );

    lsu_xc_fault u_fault (
        .req_valid_i   (req_valid_i),
        .is_store_i    (req_store_i),
        .misalign_i    (req_misalign_i),
        .xlat_on_i     (xlat_on_i),
        .hit_i         (tlb_hit_i),
        .page_fault_i  (pg_fault),
        .deny_i        (prot_deny_i),
        .walk_err_i    (walk_err_i),
        .walk_access_i (walk_access_i),
        .valid_o       (xlat_valid_o),
        .exc_o         (exc_valid_o),
        .code_o        (code)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) pa_q <= '0;
        else       pa_q <= pa_now;
    end

    assign prot_addr_o = pa_now;
    assign paddr_o     = pa_q;
    assign exc_cause_o = exc_valid_o ? XLEN'(code) : '0;
    assign exc_tval_o  = exc_valid_o ? XLEN'(req_vaddr_i) : '0;

endmodule

// File: rtl/lsu_xlat_check_sva.sv
module lsu_xlat_check_sva #(
    parameter int VA_W   = 39,
    parameter int PA_W   = 56,
    parameter int OFF_W  = 12,
    parameter int XLEN   = 64
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic            req_valid_i,
    input logic            req_store_i,
    input logic [VA_W-1:0] req_vaddr_i,
    input logic            req_misalign_i,
    input logic            xlat_on_i,
    input logic            user_mode_i,
    input logic            tlb_hit_i,
    input logic            tlb_u_i,
    input logic            walk_err_i,
    input logic            walk_access_i,
    input logic            xlat_valid_o,
    input logic [PA_W-1:0] paddr_o,
    input logic            exc_valid_o,
    input logic [XLEN-1:0] exc_cause_o,
    input logic [XLEN-1:0] exc_tval_o
);
    // R2: a miss without walker error yields nothing
    a_r2_miss_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_i && xlat_on_i && !req_misalign_i && !tlb_hit_i && !walk_err_i)
        |-> (!xlat_valid_o && !exc_valid_o));

    // R4: offset reaches the registered address one edge later
    a_r4_offset_delay: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (paddr_o[OFF_W-1:0] == $past(req_vaddr_i[OFF_W-1:0])));

    // R7 / R8: a user-mode hit on a supervisor page is a page fault whatever the protection verdict
    a_r7_user_page_fault: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_i && xlat_on_i && !req_misalign_i && tlb_hit_i && user_mode_i && !tlb_u_i)
        |-> (exc_valid_o && (exc_cause_o == (req_store_i ? XLEN'(15) : XLEN'(13)))));

    // R9: walker access errors always report the load access code
    a_r9_walk_access_load: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_i && xlat_on_i && !req_misalign_i && !tlb_hit_i && walk_err_i && walk_access_i)
        |-> (exc_valid_o && exc_cause_o == XLEN'(5)));

    // R10: no page fault with translation off
    a_r10_bare_no_page: assert property (@(posedge clk_i) disable iff (rst_i)
        (!xlat_on_i && exc_valid_o) |-> (exc_cause_o == XLEN'(5) || exc_cause_o == XLEN'(7)));

    // R11: misaligned requests raise nothing here
    a_r11_misalign_silent: assert property (@(posedge clk_i) disable iff (rst_i)
        req_misalign_i |-> (!exc_valid_o && (xlat_valid_o == req_valid_i)));

    // R12: no request, no output; trap value is the address
    a_r12_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_valid_i |-> (!exc_valid_o && !xlat_valid_o));
    a_r12_tval: assert property (@(posedge clk_i) disable iff (rst_i)
        exc_valid_o |-> (exc_tval_o == XLEN'(req_vaddr_i)));
endmodule

bind lsu_xlat_check lsu_xlat_check_sva #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .XLEN(XLEN)
) u_sva (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .req_valid_i    (req_valid_i),
    .req_store_i    (req_store_i),
    .req_vaddr_i    (req_vaddr_i),
    .req_misalign_i (req_misalign_i),
    .xlat_on_i      (xlat_on_i),
    .user_mode_i    (user_mode_i),
    .tlb_hit_i      (tlb_hit_i),
    .tlb_u_i        (tlb_u_i),
    .walk_err_i     (walk_err_i),
    .walk_access_i  (walk_access_i),
    .xlat_valid_o   (xlat_valid_o),
    .paddr_o        (paddr_o),
    .exc_valid_o    (exc_valid_o),
    .exc_cause_o    (exc_cause_o),
    .exc_tval_o     (exc_tval_o)
);

// File: tb/tb_lsu_xlat_check.sv
module tb_lsu_xlat_check;
    localparam int VA_W = 39;
    localparam int PA_W = 56;
    localparam int PPN_W = 44;
    localparam int XLEN = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic             req_valid, req_store, req_mis, xlat_on, user_mode, sum, mxr;
    logic [VA_W-1:0]  vaddr;
    logic             hit, r, w, x, u, d, werr, wacc, deny;
    logic [PPN_W-1:0] ppn;
    logic [1:0]       lvl;
    logic [PA_W-1:0]  prot_addr, paddr;
    logic             xv, ev;
    logic [PPN_W-1:0] ppn_out;
    logic [XLEN-1:0]  cause, tval;

    lsu_xlat_check dut (
        .clk_i(clk), .rst_i(rst), .req_valid_i(req_valid), .req_store_i(req_store),
        .req_vaddr_i(vaddr), .req_misalign_i(req_mis), .xlat_on_i(xlat_on),
        .user_mode_i(user_mode), .sum_i(sum), .mxr_i(mxr), .tlb_hit_i(hit),
        .tlb_ppn_i(ppn), .tlb_lvl_i(lvl), .tlb_r_i(r), .tlb_w_i(w), .tlb_x_i(x),
        .tlb_u_i(u), .tlb_d_i(d), .walk_err_i(werr), .walk_access_i(wacc),
        .prot_addr_o(prot_addr), .prot_deny_i(deny), .xlat_valid_o(xv),
        .ppn_o(ppn_out), .paddr_o(paddr), .exc_valid_o(ev), .exc_cause_o(cause),
        .exc_tval_o(tval)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [PA_W-1:0] exp_pa(logic [VA_W-1:0] va, logic [PPN_W-1:0] p, int l);
        logic [PPN_W-1:0] m  = (PPN_W'(1) << (9*l)) - PPN_W'(1);
        logic [PPN_W-1:0] vp = PPN_W'(va >> 12);
        return {(p & ~m) | (vp & m), va[11:0]};
    endfunction

    typedef struct packed {
        logic [3:0] rq;
        logic xl, mis, st, usr, sm, mx, ht;
        logic [1:0] lv;
        logic pr, pw, px, pu, pd;
        logic we, wa, dn;
        logic e_v, e_x;
        logic [4:0] e_c;
    } vec_t;

    localparam int NV = 23;
    // rq xl mis st usr sum mxr hit lvl r w x u d werr wacc deny | valid exc cause
    localparam vec_t VEC [NV] = '{
        '{4'd6, 1,0,0,0,0,0,1,2'd0, 1,0,0,0,0, 0,0,0, 1,0,5'd0 },  // R6 readable load
        '{4'd6, 1,0,0,0,0,0,1,2'd0, 0,0,1,0,0, 0,0,0, 1,1,5'd13},  // R6 exec-only, mxr off
        '{4'd6, 1,0,0,0,0,1,1,2'd0, 0,0,1,0,0, 0,0,0, 1,0,5'd0 },  // R6 exec-only, mxr on
        '{4'd5, 1,0,1,0,0,0,1,2'd0, 1,1,0,0,1, 0,0,0, 1,0,5'd0 },  // R5 good store
        '{4'd5, 1,0,1,0,0,0,1,2'd0, 1,0,0,0,1, 0,0,0, 1,1,5'd15},  // R5 not writable
        '{4'd5, 1,0,1,0,0,0,1,2'd0, 1,1,0,0,0, 0,0,0, 1,1,5'd15},  // R5 clean page
        '{4'd7, 1,0,0,1,0,0,1,2'd0, 1,0,0,0,0, 0,0,0, 1,1,5'd13},  // R7 user on S page
        '{4'd7, 1,0,0,1,0,0,1,2'd0, 1,0,0,1,0, 0,0,0, 1,0,5'd0 },  // R7 user on U page
        '{4'd7, 1,0,0,0,0,0,1,2'd0, 1,0,0,1,0, 0,0,0, 1,1,5'd13},  // R7 S on U page, sum off
        '{4'd7, 1,0,0,0,1,0,1,2'd0, 1,0,0,1,0, 0,0,0, 1,0,5'd0 },  // R7 S on U page, sum on
        '{4'd8, 1,0,0,0,0,0,1,2'd0, 1,0,0,0,0, 0,0,1, 1,1,5'd5 },  // R8 load denied
        '{4'd8, 1,0,1,0,0,0,1,2'd0, 1,1,0,0,1, 0,0,1, 1,1,5'd7 },  // R8 store denied
        '{4'd8, 1,0,1,0,0,0,1,2'd0, 1,0,0,0,1, 0,0,1, 1,1,5'd15},  // R8 page fault wins
        '{4'd2, 1,0,0,0,0,0,0,2'd0, 0,0,0,0,0, 0,0,1, 0,0,5'd0 },  // R2 plain miss
        '{4'd9, 1,0,1,0,0,0,0,2'd0, 0,0,0,0,0, 1,0,0, 1,1,5'd15},  // R9 walker page, store
        '{4'd9, 1,0,0,0,0,0,0,2'd0, 0,0,0,0,0, 1,0,0, 1,1,5'd13},  // R9 walker page, load
        '{4'd9, 1,0,1,0,0,0,0,2'd0, 0,0,0,0,0, 1,1,0, 1,1,5'd5 },  // R9 walker access, store
        '{4'd10,0,0,1,0,0,0,0,2'd0, 0,0,0,0,0, 0,0,1, 1,1,5'd7 },  // R10 bare store denied
        '{4'd10,0,0,0,0,0,0,0,2'd0, 0,0,0,0,0, 0,0,1, 1,1,5'd5 },  // R10 bare load denied
        '{4'd10,0,0,0,1,0,0,1,2'd0, 0,0,0,0,0, 0,0,0, 1,0,5'd0 },  // R10 bare, no page check
        '{4'd11,1,1,1,0,0,0,1,2'd0, 1,0,0,0,0, 0,0,1, 1,0,5'd0 },  // R11 misaligned translated
        '{4'd11,0,1,0,0,0,0,0,2'd0, 0,0,0,0,0, 0,0,1, 1,0,5'd0 },  // R11 misaligned bare
        '{4'd7, 1,0,1,1,0,0,1,2'd0, 1,1,0,1,1, 0,0,0, 1,0,5'd0 }   // R7 user store ok
    };

    localparam logic [VA_W-1:0]  VA0  = 39'h5A_BCDE_F123;
    localparam logic [PPN_W-1:0] PPN0 = 44'hFED_CBA9_8765;

    task automatic idle();
        req_valid = 0; req_store = 0; req_mis = 0; xlat_on = 0; user_mode = 0;
        sum = 0; mxr = 0; hit = 0; r = 0; w = 0; x = 0; u = 0; d = 0;
        werr = 0; wacc = 0; deny = 0; lvl = 0; vaddr = VA0; ppn = PPN0;
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset paddr", 64'(paddr), 64'd0);
        rst = 1'b0;

        foreach (VEC[i]) begin
            vec_t v = VEC[i];
            @(negedge clk);
            idle();
            req_valid = 1; xlat_on = v.xl; req_mis = v.mis; req_store = v.st;
            user_mode = v.usr; sum = v.sm; mxr = v.mx; hit = v.ht; lvl = v.lv;
            r = v.pr; w = v.pw; x = v.px; u = v.pu; d = v.pd;
            werr = v.we; wacc = v.wa; deny = v.dn;
            #2;
            chk($sformatf("R%0d vec%0d valid", v.rq, i), 64'(xv), 64'(v.e_v));
            chk($sformatf("R%0d vec%0d exc", v.rq, i), 64'(ev), 64'(v.e_x));
            if (v.e_x) begin
                chk($sformatf("R%0d vec%0d cause", v.rq, i), cause, 64'(v.e_c));
                chk($sformatf("R12 vec%0d tval", i), tval, 64'(VA0));
            end
        end

        // R3 / R4: page levels, same-cycle page number, registered address
        for (int l = 0; l < 3; l++) begin
            @(negedge clk);
            idle();
            req_valid = 1; xlat_on = 1; hit = 1; r = 1; lvl = 2'(l);
            #2;
            chk($sformatf("R3 lvl%0d prot_addr", l), 64'(prot_addr), 64'(exp_pa(VA0, PPN0, l)));
            chk($sformatf("R4 lvl%0d ppn same cycle", l), 64'(ppn_out), 64'(exp_pa(VA0, PPN0, l) >> 12));
            @(posedge clk);
            #2;
            chk($sformatf("R4 lvl%0d paddr next cycle", l), 64'(paddr), 64'(exp_pa(VA0, PPN0, l)));
        end

        // R10: bare address passes through, second address pattern
        @(negedge clk);
        idle();
        req_valid = 1; vaddr = 39'h01_0000_0ABC;
        @(posedge clk);
        #2;
        chk("R10 bare paddr", 64'(paddr), 64'h01_0000_0ABC);

        // R12: no request, denial and walker error present
        @(negedge clk);
        idle();
        xlat_on = 1; werr = 1; deny = 1;
        #2;
        chk("R12 idle exc", 64'(ev), 64'd0);
        chk("R12 idle valid", 64'(xv), 64'd0);

        // R1: reset again clears the register
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        chk("R1 reset reapplied", 64'(paddr), 64'd0);
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule